// File: doc/BRIEF.md
# Program Counter and Branch-Target Fetch Unit

This unit holds the program counter of a single-cycle processor and provides the fetch address for a word-organised instruction memory. On each rising clock edge the counter takes one of two values. The sequential value is the current counter plus four. The branch value is the counter plus four, plus the sign-extended 16-bit immediate of the current instruction shifted left by two bit positions. The branch value is used only when the datapath asserts the branch select and reports that the two compared registers are equal. In every other case the sequential value is used.

The instruction memory is outside the unit. The unit drives the word address, which is the counter with its two low bits removed. It takes the returned word combinationally and presents it as the fetched instruction in the same cycle.

The reset input is asynchronous and active low. Asserting it clears the counter at once. Its release goes through a two-stage synchroniser, so the counter stays at zero for two further rising edges and first advances on the third rising edge after release.

Top module: `pc_fetch_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0 without waiting for a clock edge. After `rst_n` rises, `pc` stays 0 across the next two rising edges.
- R2: `imem_addr` always equals `pc` with its two least significant bits removed, i.e. `pc[31:2]`.
- R3: `instr` always equals the word the memory returns on `imem_rdata` for the current `imem_addr`, in the same cycle.
- R4: With `br_sel` = 0, the next `pc` is the current `pc` + 4, whatever the value of `eq_flag`.
- R5: With `br_sel` = 1 and `eq_flag` = 1, the next `pc` is the current `pc` + 4 + (sign-extended `imm16` × 4).
- R6: With `br_sel` = 1 and `eq_flag` = 0, the next `pc` is the current `pc` + 4.
- R7: Bit 15 of `imm16` is the sign bit. 16'hFFFF branches back to the current `pc`, and 16'h8000 moves the counter by −131068 bytes.
- R8: `pc[1:0]` is always 2'b00.
- R9: All address arithmetic wraps modulo 2^32. A taken branch from address 0 with `imm16` = 16'hFFFE reaches 32'hFFFF_FFFC, and the next sequential step returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imm16 | input | 16 | Immediate field of the current instruction (branch offset in words) |
| br_sel | input | 1 | Next-address select: 1 requests the branch path |
| eq_flag | input | 1 | Equality result of the two compared registers |
| imem_rdata | input | 32 | Word returned by the instruction memory |
| imem_addr | output | 30 | Word address to the instruction memory |
| pc | output | 32 | Current program counter (byte address) |
| instr | output | 32 | Fetched instruction word |

## Verification
The assertions check every cycle that the counter is held at zero while the synchronised reset is active. They also check that it stays word-aligned, and that each clock edge advances it by exactly the amount set by the select, the equality flag and the immediate sampled one edge earlier. Three behaviours appear only in the bench's directed scenarios, against a behavioural model that runs alongside the design:
- the asynchronous clear in the middle of a run;
- the two-edge hold after release;
- the address wrap through 32'hFFFF_FFFC.

The fetched word matching the memory at the driven word address is likewise shown only by the bench.

// File: rtl/fetch_pkg.sv
`timescale 1ns/1ps
package fetch_pkg;
  // Source of the value loaded into the counter at the next edge
  typedef enum logic {
    NPC_SEQ    = 1'b0,
    NPC_BRANCH = 1'b1
  } npc_src_e;

  // Byte-to-word address shift for a 4-byte instruction word
  localparam int unsigned WORD_SHIFT = 2;
endpackage

// File: rtl/fetch_rst_sync.sv
`timescale 1ns/1ps
module fetch_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[LAST];
endmodule

// File: rtl/fetch_npc_adders.sv
`timescale 1ns/1ps
module fetch_npc_adders
  import fetch_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [IMM_W-1:0] offset_words,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  target_pc
);
  localparam int unsigned EXT_W = PC_W - IMM_W - WORD_SHIFT;
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << WORD_SHIFT;

  logic [PC_W-1:0] offset_bytes;

  always_comb begin
    offset_bytes = {{EXT_W{offset_words[IMM_W-1]}}, offset_words, {WORD_SHIFT{1'b0}}};
    seq_pc       = cur_pc + STEP;
    // Offset is relative to the sequential address, not the current one
    target_pc    = seq_pc + offset_bytes;
  end
endmodule

// File: rtl/fetch_pc_reg.sv
`timescale 1ns/1ps
module fetch_pc_reg
  import fetch_pkg::*;
#(
  parameter int unsigned     PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            srst_n,
  input  npc_src_e        src,
  input  logic [PC_W-1:0] seq_pc,
  input  logic [PC_W-1:0] target_pc,
  output logic [PC_W-1:0] pc_q
);
  logic [PC_W-1:0] pc_d;

  always_comb begin
    unique case (src)
      NPC_BRANCH: pc_d = target_pc;
      default:    pc_d = seq_pc;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) pc_q <= RESET_PC;
    else         pc_q <= pc_d;
  end

  // R8: counter never leaves a word boundary
  p_aligned_r8: assert property (@(posedge clk) disable iff (!srst_n)
    pc_q[WORD_SHIFT-1:0] == '0);
endmodule

// File: rtl/pc_fetch_unit.sv
`timescale 1ns/1ps
module pc_fetch_unit
  import fetch_pkg::*;
#(
  parameter int unsigned     PC_W       = 32,
  parameter int unsigned     IMM_W      = 16,
  parameter int unsigned     INSTR_W    = 32,
  parameter int unsigned     SYNC_STAGE = 2,
  parameter logic [PC_W-1:0] RESET_PC   = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IMM_W-1:0]           imm16,
  input  logic                       br_sel,
  input  logic                       eq_flag,
  input  logic [INSTR_W-1:0]         imem_rdata,
  output logic [PC_W-WORD_SHIFT-1:0] imem_addr,
  output logic [PC_W-1:0]            pc,
  output logic [INSTR_W-1:0]         instr
);
  localparam int unsigned EXT_W = PC_W - IMM_W - WORD_SHIFT;

  logic            srst_n;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] target_pc;
  npc_src_e        src;

  fetch_rst_sync #(.STAGES(SYNC_STAGE)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fetch_npc_adders #(.PC_W(PC_W), .IMM_W(IMM_W)) u_adders (
    .cur_pc       (pc),
    .offset_words (imm16),
    .seq_pc       (seq_pc),
    .target_pc    (target_pc)
  );

  // Branch path only when requested and the compared values match
  always_comb begin
    src = (br_sel && eq_flag) ? NPC_BRANCH : NPC_SEQ;
  end

  fetch_pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk       (clk),
    .srst_n    (srst_n),
    .src       (src),
    .seq_pc    (seq_pc),
    .target_pc (target_pc),
    .pc_q      (pc)
  );

  assign imem_addr = pc[PC_W-1:WORD_SHIFT];
  assign instr     = imem_rdata;

  // R1: counter held at the reset address while reset is active
  p_reset_hold_r1: assert property (@(posedge clk)
    !srst_n |-> pc == RESET_PC);

  // R4: no branch request gives a plain increment
  p_seq_step_r4: assert property (@(posedge clk) disable iff (!srst_n)
    !br_sel |=> pc == $past(pc) + PC_W'(4));

  // R6: request without equality still increments
  p_not_taken_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (br_sel && !eq_flag) |=> pc == $past(pc) + PC_W'(4));

  // R5: taken branch lands at sequential address plus scaled offset
  p_taken_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (br_sel && eq_flag) |=> pc == $past(pc) + PC_W'(4)
      + {{EXT_W{$past(imm16[IMM_W-1])}}, $past(imm16), 2'b00});
endmodule

// File: tb/pc_fetch_unit_test.sv
`timescale 1ns/1ps
module pc_fetch_unit_test;
  logic        clk;
  logic        rst_n;
  logic [15:0] imm16;
  logic        br_sel;
  logic        eq_flag;
  logic [31:0] imem_rdata;
  logic [29:0] imem_addr;
  logic [31:0] pc;
  logic [31:0] instr;

  int checks;
  int errors;
  bit finished;
  logic [31:0] exp_pc;

  pc_fetch_unit uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imm16      (imm16),
    .br_sel     (br_sel),
    .eq_flag    (eq_flag),
    .imem_rdata (imem_rdata),
    .imem_addr  (imem_addr),
    .pc         (pc),
    .instr      (instr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural ROM: a computed word per address
  function automatic logic [31:0] rom_word(logic [29:0] a);
    logic [31:0] w;
    w = {2'b00, a} * 32'h9E37_79B1;
    return w ^ 32'hC0FF_EE00;
  endfunction

  always_comb imem_rdata = rom_word(imem_addr);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    check(tag, pc, exp_pc);
    check("R2", {2'b00, imem_addr}, {2'b00, exp_pc[31:2]});
    check("R3", instr, rom_word(exp_pc[31:2]));
    check("R8", {30'd0, pc[1:0]}, 32'd0);
  endtask

  // Drive at negedge, one rising edge, compare at the following negedge
  task automatic step(logic sel, logic eq, logic [15:0] imm, string force_tag);
    longint nxt;
    string tag;
    br_sel  = sel;
    eq_flag = eq;
    imm16   = imm;
    nxt = longint'(exp_pc) + 4;
    if (sel && eq) nxt = nxt + longint'($signed(imm)) * 4;
    if (force_tag != "")   tag = force_tag;
    else if (!sel)         tag = "R4";
    else if (eq)           tag = "R5";
    else                   tag = "R6";
    @(posedge clk);
    @(negedge clk);
    exp_pc = nxt[31:0];
    check_outputs(tag);
  endtask

  task automatic release_reset();
    rst_n  = 1'b1;
    br_sel = 1'b1; eq_flag = 1'b1; imm16 = 16'h0100;
    @(posedge clk); @(negedge clk);
    check("R1", pc, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R1", pc, 32'd0);
    exp_pc = 32'd0;
  endtask

  initial begin
    if (!finished) begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
        finished = 1'b1;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0; br_sel = 1'b0; eq_flag = 1'b0; imm16 = 16'h0;
    exp_pc = 32'd0;
    repeat (3) @(negedge clk);
    check("R1", pc, 32'd0);
    check("R3", instr, rom_word(30'd0));
    release_reset();

    // Sequential, including equality asserted without request (R4)
    step(1'b0, 1'b0, 16'h1234, "");
    step(1'b0, 1'b1, 16'h0040, "R4");
    step(1'b0, 1'b1, 16'hFFFF, "R4");
    // Forward taken branch (R5)
    step(1'b1, 1'b1, 16'h0010, "R5");
    // Request without equality (R6)
    step(1'b1, 1'b0, 16'h0200, "R6");
    // Negative offsets (R7)
    step(1'b1, 1'b1, 16'hFFFF, "R7");
    step(1'b1, 1'b1, 16'h7FFF, "R5");
    step(1'b1, 1'b1, 16'h8000, "R7");
    step(1'b1, 1'b1, 16'hFFFC, "R7");

    // Asynchronous clear mid-run, then wrap check from address 0
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5 check("R1", pc, 32'd0);
    @(negedge clk);
    release_reset();
    step(1'b1, 1'b1, 16'hFFFE, "R9");
    check("R9", pc, 32'hFFFF_FFFC);
    step(1'b0, 1'b0, 16'h0000, "R9");
    check("R9", pc, 32'd0);

    // Mixed patterns
    void'($urandom(32'd7331));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[31:16], "");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule